// File: doc/BRIEF.md
# Periodic Calibration Sequencer

This block steps through a short circular list of periodic calibrations. Each list entry is either an IQ mismatch measurement or a temperature compensation measurement. The caller pulses `tick_i` once per calibration interval. On each tick the block looks at the current entry and decides what to do. It may launch a measurement or leave a running one alone. When the measurement hardware has cleared its start bit, the block collects a finished sub-sample. Once enough sub-samples have been gathered, it requests post-processing and advances to the next entry.

An IQ launch drives the start strobe together with a log2 sample-count field, and the measurement then spans 2^(field+1) samples. When post-processing is requested, the block also gives the number of active receive chains. When an entry completes, its type bit is set in a per-channel valid mask. If the entry that follows is still waiting, the done status is held back from the caller and that entry is launched at once. A long-calibration tick also requests a noise-floor load and then a noise-floor start, whatever state the list is in.

Top module: `periodic_cal_seq`

## Requirements
- R1: During and right after reset, every strobe is low, `valid_mask_o` is 0 and `done_o` is 1.
- R2: `init_i` clears `valid_mask_o`, drives `done_o` low, and launches entry 0 one cycle later. For an IQ entry the launch is `acc_clear_o` together with `iq_start_o`, with `iq_log_count_o` equal to IQ_LOG_COUNT.
- R3: A tick with `meas_busy_i` high while the current entry runs produces no strobe, and `done_o` reads 0.
- R4: A tick with `meas_busy_i` low while the entry runs pulses `collect_o`. If the sub-sample count is still below NUM_SAMPLES, the same entry's start strobe is pulsed again, without `acc_clear_o`.
- R5: The tick that brings the count to NUM_SAMPLES also pulses `post_proc_o`. On that tick `num_chains_o` equals the popcount of `rx_chain_mask_i`, and the entry's type bit is ORed into `valid_mask_o` (bit 0 for IQ, bit 1 for temperature).
- R6: If the entry after a completed one is waiting, `done_o` stays 0 and that entry is launched in the same cycle, with `acc_clear_o` and its own start strobe (`temp_start_o` for a temperature entry).
- R7: If the entry after a completed one is already done, `done_o` goes to 1, and later ticks produce no strobes and keep `done_o` at 1.
- R8: A tick with `long_cal_i` high pulses `nf_load_o` one cycle later and `nf_start_o` the cycle after that, regardless of the list state.
- R9: Before any `init_i`, a tick produces no calibration strobe and leaves `done_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Build the list and launch entry 0 |
| tick_i | input | 1 | Periodic calibration call |
| long_cal_i | input | 1 | Add the noise-floor requests to this tick |
| rx_chain_mask_i | input | CHAINS | Active receive chains |
| meas_busy_i | input | 1 | Measurement start bit read back |
| iq_start_o | output | 1 | Set the IQ measurement start bit |
| iq_log_count_o | output | LOG_W | Log2 sample-count field for IQ launches |
| temp_start_o | output | 1 | Start a temperature measurement |
| acc_clear_o | output | 1 | Clear the per-chain accumulators |
| collect_o | output | 1 | Accumulate one finished sub-sample |
| post_proc_o | output | 1 | Process the accumulated data |
| num_chains_o | output | $clog2(CHAINS+1) | Active chain count for post-processing |
| valid_mask_o | output | 2 | Per-channel calibration valid bits |
| done_o | output | 1 | Done status reported for the last tick |
| nf_load_o | output | 1 | Noise-floor history load request |
| nf_start_o | output | 1 | Noise-floor calibration start request |

## Verification
The main scenario walks the two-entry list with the start bit alternating between busy and clear. This separates a tick that only waits from one that collects and relaunches, and both of those from one that completes. The chain mask changes across the completing ticks (all three chains, none), so a wrong popcount or a count taken from a stale mask shows up. The first completion lands on a waiting entry and the second on a finished one. This contrasts the hidden done status with the reported one and the temperature launch with the IQ launch. Long ticks are applied both before initialisation and while an entry runs, to show that the noise-floor requests do not depend on the list.

// File: rtl/pcal_pkg.sv
package pcal_pkg;
  typedef enum logic [1:0] {
    ENT_WAIT = 2'd0,
    ENT_RUN  = 2'd1,
    ENT_DONE = 2'd2
  } ent_state_e;

  localparam int unsigned NUM_TYPES = 2;
  localparam int unsigned TYPE_IQ   = 0;
  localparam int unsigned TYPE_TEMP = 1;
endpackage

// File: rtl/pcal_list.sv
module pcal_list
  import pcal_pkg::*;
#(
  parameter int unsigned N     = 2,
  parameter int unsigned IDX_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             done_en_i,
  input  logic             run_en_i,
  input  logic [IDX_W-1:0] run_idx_i,
  input  logic             adv_i,
  output logic             active_o,
  output logic [IDX_W-1:0] cur_idx_o,
  output logic [IDX_W-1:0] nxt_idx_o,
  output ent_state_e       cur_state_o,
  output ent_state_e       nxt_state_o
);
  ent_state_e       st_q [N];
  logic [IDX_W-1:0] cur_q;
  logic             active_q;
  logic [IDX_W-1:0] nxt;

  assign nxt = (cur_q == IDX_W'(N-1)) ? '0 : cur_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N); i++) st_q[i] <= ENT_WAIT;
      cur_q    <= '0;
      active_q <= 1'b0;
    end else if (init_i) begin
      for (int i = 0; i < int'(N); i++) st_q[i] <= (i == 0) ? ENT_RUN : ENT_WAIT;
      cur_q    <= '0;
      active_q <= 1'b1;
    end else begin
      for (int i = 0; i < int'(N); i++) begin
        if (run_en_i && run_idx_i == IDX_W'(i))    st_q[i] <= ENT_RUN;
        else if (done_en_i && cur_q == IDX_W'(i))  st_q[i] <= ENT_DONE;
      end
      if (adv_i) cur_q <= nxt;
    end
  end

  assign active_o    = active_q;
  assign cur_idx_o   = cur_q;
  assign nxt_idx_o   = nxt;
  assign cur_state_o = st_q[cur_q];
  assign nxt_state_o = st_q[nxt];
endmodule

// File: rtl/pcal_chain_cnt.sv
module pcal_chain_cnt #(
  parameter int unsigned CHAINS = 3,
  parameter int unsigned CNT_W  = 2
) (
  input  logic [CHAINS-1:0] mask_i,
  output logic [CNT_W-1:0]  count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < int'(CHAINS); i++) count_o = count_o + CNT_W'(mask_i[i]);
  end
endmodule

// File: rtl/pcal_nf.sv
module pcal_nf (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic load_o,
  output logic start_o
);
  logic load_q, start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      load_q  <= req_i;
      start_q <= load_q;
    end
  end

  assign load_o  = load_q;
  assign start_o = start_q;
endmodule

// File: rtl/periodic_cal_seq.sv
module periodic_cal_seq
  import pcal_pkg::*;
#(
  parameter int unsigned          CHAINS       = 3,
  parameter int unsigned          NUM_ENTRIES  = 2,
  parameter logic [NUM_ENTRIES-1:0] TEMP_MAP   = 2'b10,
  parameter int unsigned          NUM_SAMPLES  = 2,
  parameter int unsigned          LOG_W        = 4,
  parameter logic [LOG_W-1:0]     IQ_LOG_COUNT = 4'd4,
  localparam int unsigned         NCH_W        = $clog2(CHAINS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 init_i,
  input  logic                 tick_i,
  input  logic                 long_cal_i,
  input  logic [CHAINS-1:0]    rx_chain_mask_i,
  input  logic                 meas_busy_i,
  output logic                 iq_start_o,
  output logic [LOG_W-1:0]     iq_log_count_o,
  output logic                 temp_start_o,
  output logic                 acc_clear_o,
  output logic                 collect_o,
  output logic                 post_proc_o,
  output logic [NCH_W-1:0]     num_chains_o,
  output logic [NUM_TYPES-1:0] valid_mask_o,
  output logic                 done_o
,
  output logic                 nf_load_o,
  output logic                 nf_start_o
);
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int unsigned CNT_W = $clog2(NUM_SAMPLES + 1);

  logic             active;
  logic [IDX_W-1:0] cur_idx, nxt_idx, run_idx;
  ent_state_e       cur_state, nxt_state;
  logic             done_en, run_en, adv;

  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [CNT_W:0]       cnt_inc;
  logic [NUM_TYPES-1:0] valid_q, valid_d, cur_bit;
  logic                 done_q, done_d;
  logic                 iq_d, temp_d, clr_d, col_d, post_d;
  logic                 iq_q, temp_q, clr_q, col_q, post_q;
  logic [LOG_W-1:0]     log_q;
  logic [NCH_W-1:0]     nch, nch_q;

  pcal_list #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_list (
    .clk_i, .rst_ni, .init_i,
    .done_en_i(done_en), .run_en_i(run_en), .run_idx_i(run_idx), .adv_i(adv),
    .active_o(active), .cur_idx_o(cur_idx), .nxt_idx_o(nxt_idx),
    .cur_state_o(cur_state), .nxt_state_o(nxt_state)
  );

  pcal_chain_cnt #(.CHAINS(CHAINS), .CNT_W(NCH_W)) u_cnt (
    .mask_i(rx_chain_mask_i), .count_o(nch)
  );

  pcal_nf u_nf (
    .clk_i, .rst_ni, .req_i(tick_i & long_cal_i),
    .load_o(nf_load_o), .start_o(nf_start_o)
  );

  assign cur_bit = TEMP_MAP[cur_idx] ? NUM_TYPES'(1 << TYPE_TEMP) : NUM_TYPES'(1 << TYPE_IQ);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_d   = cnt_q;
    valid_d = valid_q;
    done_d  = done_q;
    iq_d    = 1'b0;
    temp_d  = 1'b0;
    clr_d   = 1'b0;
    col_d   = 1'b0;
    post_d  = 1'b0;
    done_en = 1'b0;
    run_en  = 1'b0;
    run_idx = cur_idx;
    adv     = 1'b0;
    if (init_i) begin
      cnt_d   = '0;
      valid_d = '0;
      done_d  = 1'b0;
      clr_d   = 1'b1;
      iq_d    = ~TEMP_MAP[0];
      temp_d  = TEMP_MAP[0];
    end else if (tick_i) begin
      done_d = 1'b1;
      if (active && (cur_state == ENT_RUN || cur_state == ENT_WAIT)) begin
        done_d = 1'b0;
        if (cur_state == ENT_RUN) begin
          if (!meas_busy_i) begin
            col_d = 1'b1;
            cnt_d = cnt_inc[CNT_W-1:0];
            if (cnt_inc >= (CNT_W+1)'(NUM_SAMPLES)) begin
              post_d  = 1'b1;
              valid_d = valid_q | cur_bit;
              done_en = 1'b1;
            end else begin
              iq_d   = ~TEMP_MAP[cur_idx];
              temp_d = TEMP_MAP[cur_idx];
            end
          end
        end else if ((valid_q & cur_bit) == '0) begin
          run_en = 1'b1;
          clr_d  = 1'b1;
          cnt_d  = '0;
          iq_d   = ~TEMP_MAP[cur_idx];
          temp_d = TEMP_MAP[cur_idx];
        end
        // completion: hide done while the next entry still waits
        if (done_en) begin
          adv = 1'b1;
          if (nxt_state == ENT_WAIT) begin
            run_en  = 1'b1;
            run_idx = nxt_idx;
            clr_d   = 1'b1;
            cnt_d   = '0;
            iq_d    = ~TEMP_MAP[nxt_idx];
            temp_d  = TEMP_MAP[nxt_idx];
          end else begin
            done_d = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= '0;
      done_q  <= 1'b1;
      iq_q    <= 1'b0;
      temp_q  <= 1'b0;
      clr_q   <= 1'b0;
      col_q   <= 1'b0;
      post_q  <= 1'b0;
      log_q   <= '0;
      nch_q   <= '0;
    end else begin
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
      done_q  <= done_d;
      iq_q    <= iq_d;
      temp_q  <= temp_d;
      clr_q   <= clr_d;
      col_q   <= col_d;
      post_q  <= post_d;
      if (iq_d)   log_q <= IQ_LOG_COUNT;
      if (post_d) nch_q <= nch;
    end
  end

  assign iq_start_o     = iq_q;
  assign iq_log_count_o = log_q;
  assign temp_start_o   = temp_q;
  assign acc_clear_o    = clr_q;
  assign collect_o      = col_q;
  assign post_proc_o    = post_q;
  assign num_chains_o   = nch_q;
  assign valid_mask_o   = valid_q;
  assign done_o         = done_q;
endmodule

// File: rtl/pcal_checker.sv
module pcal_checker #(
  parameter int unsigned CHAINS = 3,
  localparam int unsigned NCH_W = $clog2(CHAINS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_i,
  input logic              tick_i,
  input logic              long_cal_i,
  input logic [CHAINS-1:0] rx_chain_mask_i,
  input logic              meas_busy_i,
  input logic              iq_start_o,
  input logic              temp_start_o,
  input logic              acc_clear_o,
  input logic              collect_o,
  input logic              post_proc_o,
  input logic [NCH_W-1:0]  num_chains_o,
  input logic [1:0]        valid_mask_o,
  input logic              done_o,
  input logic              nf_load_o,
  input logic              nf_start_o
);
  p_quiet_no_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tick_i) && !$past(init_i)) |-> (!collect_o && !iq_start_o && !temp_start_o));

  p_collect_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collect_o |-> ($past(tick_i) && !$past(meas_busy_i) && !$past(init_i)));

  p_post_with_collect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_proc_o |-> collect_o);

  p_chain_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_proc_o |-> (num_chains_o == NCH_W'($countones($past(rx_chain_mask_i)))));

  p_valid_grows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_i |=> ((valid_mask_o & $past(valid_mask_o)) == $past(valid_mask_o)));

  p_one_launch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(iq_start_o && temp_start_o));

  p_hidden_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_proc_o && !done_o) |-> ((iq_start_o || temp_start_o) && acc_clear_o));

  p_nf_load_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nf_load_o |-> ($past(tick_i) && $past(long_cal_i)));

  p_nf_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nf_start_o |-> $past(nf_load_o));
endmodule

bind periodic_cal_seq pcal_checker #(.CHAINS(CHAINS)) u_chk (.*);

// File: tb/tb_periodic_cal_seq.sv
module tb_periodic_cal_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       init_i = 1'b0, tick_i = 1'b0, long_cal_i = 1'b0, meas_busy_i = 1'b0;
  logic [2:0] rx_chain_mask_i = '0;
  logic       iq_start_o, temp_start_o, acc_clear_o, collect_o, post_proc_o, done_o;
  logic       nf_load_o, nf_start_o;
  logic [3:0] iq_log_count_o;
  logic [1:0] num_chains_o, valid_mask_o;

  int tests = 0, fails = 0;
  bit finished = 0;

  periodic_cal_seq dut (.*);

  always #5 clk_i = ~clk_i;

  // {tick,busy,long,mask[2:0], collect,post,nch[1:0],iq,temp,clr,done,valid[1:0]}
  localparam logic [15:0] VEC [8] = '{
    16'b1_1_0_000_0_0_00_0_0_0_0_00,
    16'b1_0_0_101_1_0_00_1_0_0_0_00,
    16'b1_0_0_111_1_1_11_0_1_1_0_01,
    16'b1_1_1_000_0_0_00_0_0_0_0_01,
    16'b1_0_0_010_1_0_00_0_1_0_0_01,
    16'b1_0_0_000_1_1_00_0_0_0_1_11,
    16'b1_0_0_011_0_0_00_0_0_0_1_11,
    16'b1_0_1_110_0_0_00_0_0_0_1_11
  };

  function automatic string row_tag(int i);
    case (i)
      0, 3:    return "R3";
      1, 4:    return "R4";
      2:       return "R6";
      5, 6:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobes_idle(string req);
    check(req, {iq_start_o, temp_start_o, acc_clear_o, collect_o, post_proc_o}, 16'h0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] done_hold;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 done", done_o, 1);
    check("R1 valid", valid_mask_o, 0);
    strobes_idle("R1 strobes");
    check("R1 nf", {nf_load_o, nf_start_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 tick with no list
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    strobes_idle("R9 strobes");
    check("R9 done", done_o, 1);

    // R8 long tick before init
    tick_i = 1'b1; long_cal_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0; long_cal_i = 1'b0;
    check("R8 load", {nf_load_o, nf_start_o}, 2'b10);
    @(negedge clk_i);
    check("R8 start", {nf_load_o, nf_start_o}, 2'b01);
    @(negedge clk_i);
    check("R8 idle", {nf_load_o, nf_start_o}, 2'b00);

    // R2 init
    init_i = 1'b1;
    @(negedge clk_i);
    init_i = 1'b0;
    check("R2 launch", {iq_start_o, temp_start_o, acc_clear_o}, 3'b101);
    check("R2 log field", iq_log_count_o, 4);
    check("R2 done", done_o, 0);
    check("R2 valid", valid_mask_o, 0);
    @(negedge clk_i);

    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      v = VEC[i];
      tick_i = v[15]; meas_busy_i = v[14]; long_cal_i = v[13]; rx_chain_mask_i = v[12:10];
      @(negedge clk_i);
      tick_i = 1'b0; long_cal_i = 1'b0; meas_busy_i = 1'b1;
      check(row_tag(i), {collect_o, post_proc_o}, {14'd0, v[9:8]});
      if (v[8]) check("R5 chains", num_chains_o, v[7:6]);
      check(row_tag(i), {iq_start_o, temp_start_o, acc_clear_o}, {13'd0, v[5:3]});
      check(row_tag(i), done_o, v[2]);
      check("R5 valid", valid_mask_o, v[1:0]);
      check("R8 load", nf_load_o, v[15] & v[13]);
      done_hold = {1'b0, done_o};
      @(negedge clk_i);
      strobes_idle("R3 idle");
      check("R8 start", nf_start_o, v[15] & v[13]);
      check("R7 hold", done_o, done_hold[0]);
    end

    // R2 re-init after full pass clears valid bits
    init_i = 1'b1;
    @(negedge clk_i);
    init_i = 1'b0;
    check("R2 reinit valid", valid_mask_o, 0);
    check("R2 reinit launch", {iq_start_o, acc_clear_o, done_o}, 3'b110);

    // R1 reset in mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 midrun", {done_o, valid_mask_o}, 3'b100);
    strobes_idle("R1 midrun strobes");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule